// File: doc/BRIEF.md
# I2C Byte Shift Register with Bus Filtering

This block is the byte-wide data path of a multi-master I2C controller. It holds one byte: the byte about to go out on the bus, or the byte coming in from it. The raw SCL and SDA inputs are sampled on the system clock, and each passes through a digital noise filter. A shift strobe is made from every rising edge of the filtered SCL, one system clock after that edge. On every strobe the byte moves one place toward its most significant end.

In transmit mode the serial data output follows the top bit, so the byte leaves most significant bit first. Each strobe fills the bottom bit with a 1, the released bus level. In receive mode each strobe loads the filtered SDA level into bit 0. After eight strobes the first bit received sits in bit 7.

The CPU side has a write port, which loads a new byte, and a read port, which shows the register at all times. A busy flag covers one byte transfer. A write is accepted only while the interface is enabled and no transfer is in progress. Start and stop generation, arbitration, acknowledge handling and address matching belong to neighbouring blocks.

Top module: `i2c_byte_shifter`

## Requirements
- R1: The filtered copy of SCL or SDA takes a new level only when two consecutive system-clock samples of the raw input show that level. A raw pulse seen at a single sample leaves the filtered level unchanged.
- R2: A shift strobe happens one system clock after each rising edge of the filtered SCL, and each such edge gives exactly one shift of the register.
- R3: `sda_out` always equals bit 7 of the register. In transmit mode (`tx_mode`=1) a written byte therefore leaves bit 7 first, and each shift fills bit 0 with 1. After eight shifts the register reads 8'hFF.
- R4: In receive mode (`tx_mode`=0) each shift loads the filtered SDA level into bit 0. After eight shifts, the bit received first is in bit 7 and the bit received last is in bit 0.
- R5: A write (`wr_en`=1) with `enable`=1 and `busy`=0 loads `wr_data`, which appears on `rd_data` on the next clock.
- R6: A write while `busy`=1 leaves the register unchanged.
- R7: `busy` becomes 1 after an accepted write or after the first shift of a transfer. It stays 1 until the eighth shift, and it returns to 0 in the same clock as that shift.
- R8: While `enable`=0, writes are ignored and SCL rising edges cause no shift.
- R9: After reset `busy` is 0 and both filters hold the idle bus level 1. The register contents after reset are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the filter sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Interface enable |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Current register contents |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| scl_in | input | 1 | Raw bus clock |
| sda_in | input | 1 | Raw bus data |
| sda_out | output | 1 | Serial data output (register bit 7) |
| busy | output | 1 | Byte transfer in progress |

## Verification
Several properties are checked on every cycle. The filter may change its output only after two equal raw samples. A strobe may only follow a filtered SCL rise. `busy` may fall only on a strobe. Writes are ignored while busy, and nothing moves while the interface is disabled. Other behaviour needs the bench's scenarios, because it depends on the whole order of bits across a transfer. Those scenarios show the byte values after transmit and receive transfers, the order in which bits appear on `sda_out`, the 1-fill in transmit mode, and that a single-sample SCL glitch adds no shift while a two-sample pulse does.

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         tx_mode,
  input  logic         scl_in,
  input  logic         sda_in,
  output logic         sda_out,
  output logic         busy
);
  localparam int CW = $clog2(W);

  logic         scl_s, sda_s, scl_f, sda_f, scl_q, stb;
  logic [W-1:0] sreg;
  logic [CW-1:0] cnt;
  logic         wr_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 1'b1; sda_s <= 1'b1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_q <= 1'b1; stb <= 1'b0;
    end else begin
      scl_s <= scl_in;
      sda_s <= sda_in;
      if (scl_s == scl_in) scl_f <= scl_in;
      if (sda_s == sda_in) sda_f <= sda_in;
      scl_q <= scl_f;
      stb   <= scl_f & ~scl_q & enable;
    end

  assign wr_ok = wr_en & enable & ~busy;

  always_ff @(posedge clk)
    if (wr_ok)
      sreg <= wr_data;
    else if (stb)
      sreg <= {sreg[W-2:0], tx_mode ? 1'b1 : sda_f};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (wr_ok) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (stb) begin
      if (cnt == CW'(W-1)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        busy <= 1'b1;
        cnt  <= cnt + 1'b1;
      end
    end

  assign rd_data = sreg;
  assign sda_out = sreg[W-1];

  p_scl_filter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f != $past(scl_f)) |-> ($past(scl_in) == scl_f && $past(scl_in, 2) == scl_f));
  p_sda_filter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_f != $past(sda_f)) |-> ($past(sda_in) == sda_f && $past(sda_in, 2) == sda_f));
  p_strobe_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> ($past(scl_f) && !$past(scl_f, 2)));
  p_busy_fall_on_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(stb));
  p_write_ignored_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !stb) |=> $stable(sreg));
  p_disabled_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !stb) |=> ($stable(sreg) && $stable(busy)));
endmodule

// File: tb/test_i2c_byte_shifter.sv
module test_i2c_byte_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h80},
    {1'b0, 8'hD2}, {1'b1, 8'h5E}, {1'b0, 8'h01}};

  logic clk = 0, rst_n = 0, enable = 0, wr_en = 0, tx_mode = 0;
  logic scl_in = 1, sda_in = 1;
  logic [7:0] wr_data = 0, rd_data;
  logic sda_out, busy;
  int n_chk = 0, n_bad = 0;

  i2c_byte_shifter i_i2c_byte_shifter (.clk, .rst_n, .enable, .wr_en, .wr_data,
    .rd_data, .tx_mode, .scl_in, .sda_in, .sda_out, .busy);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_bit(input logic b);
    @(negedge clk); sda_in = b;
    idle(3); scl_in = 1;
    idle(6); scl_in = 0;
    idle(6);
  endtask

  initial begin
    idle(3);
    chk("R9 busy after reset", {7'd0, busy}, 8'h00);
    rst_n = 1;
    scl_in = 0;
    idle(4);
    chk("R9 busy idle", {7'd0, busy}, 8'h00);
    enable = 1;

    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      d = VEC[v][7:0];
      tx_mode = VEC[v][8];
      if (tx_mode) begin
        write(d);
        chk("R5 write loads", rd_data, d);
        chk("R7 busy after write", {7'd0, busy}, 8'h01);
        for (int i = 7; i >= 0; i--) begin
          chk("R3 sda_out bit order", {7'd0, sda_out}, {7'd0, d[i]});
          bus_bit(1'b1);
        end
        chk("R3 tx fill ones", rd_data, 8'hFF);
      end else begin
        for (int i = 7; i >= 0; i--) begin
          bus_bit(d[i]);
          if (i == 1) chk("R7 busy before eighth", {7'd0, busy}, 8'h01);
        end
        chk("R4 rx byte", rd_data, d);
      end
      chk("R7 busy clear after eighth", {7'd0, busy}, 8'h00);
    end

    tx_mode = 1;
    write(8'h96);
    bus_bit(1'b1);
    write(8'h00);
    chk("R6 write while busy ignored", rd_data, 8'h2D);
    for (int i = 0; i < 7; i++) bus_bit(1'b1);
    chk("R7 busy clear", {7'd0, busy}, 8'h00);

    write(8'h5A);
    enable = 0;
    write(8'hC3);
    chk("R8 write while disabled", rd_data, 8'h5A);
    bus_bit(1'b1);
    chk("R8 no shift while disabled", rd_data, 8'h5A);
    chk("R8 busy held", {7'd0, busy}, 8'h01);
    enable = 1;

    bus_bit(1'b1);
    chk("R2 one shift per edge", rd_data, 8'hB5);
    @(negedge clk); scl_in = 1;
    @(negedge clk); scl_in = 0;
    idle(6);
    chk("R1 one-sample glitch rejected", rd_data, 8'hB5);
    @(negedge clk); scl_in = 1;
    idle(2); scl_in = 0;
    idle(6);
    chk("R1 two-sample pulse accepted", rd_data, 8'h6B);

    tx_mode = 0;
    for (int i = 0; i < 6; i++) bus_bit(1'b0);
    chk("R7 busy done after glitch test", {7'd0, busy}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sda_in = (i == 0);
      idle(3); scl_in = 1;
      if (i == 3) begin
        @(negedge clk); sda_in = ~sda_in;
        @(negedge clk); sda_in = ~sda_in;
      end
      idle(6); scl_in = 0;
      idle(6);
    end
    chk("R1 sda glitch rejected", rd_data, 8'h80);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule